// File: doc/BRIEF.md
# Interrupt and break entry sequencer

This block runs the entry sequence that an 8-bit processor core executes when a software break or a hardware interrupt is taken. After a one-cycle start strobe, it drives a byte-wide memory bus for seven cycles. First it reads the byte after the opcode. It then stores the return address and the status byte in the stack page, sets the interrupt-disable flag, and fetches the two bytes of a new program counter from a vector slot chosen by a type byte. The last of the seven cycles is the opcode fetch at the new address.

The core hands over its PC, stack pointer and status byte together with the strobe. It takes the updated values back from `pc_o`, `s_o` and `p_o` once `done_o` pulses. A software break always uses the fixed vector type 0xFE. A hardware interrupt supplies its own type byte. The block does not arbitrate between interrupt sources.

Top module: `brk_seq`

## Requirements
- R1: After reset the block is idle: `rd_o`, `we_o` and `done_o` are 0, and `pc_o`, `s_o` and `p_o` are 0.
- R2: In the first cycle after the start strobe is taken, the block reads from the address on `pc_i`. `pc_o` advances by one only when `is_brk_i` was 1, and otherwise stays unchanged.
- R3: Cycles 2, 3 and 4 write, in that order, the PC high byte, the PC low byte and the status byte. Each write goes to address 0x0100 + S. S decrements by one after each write and wraps within 8 bits, so `s_o` equals S−3 (mod 256) afterwards.
- R4: The stored status byte equals P with bit 5 and bit 4 forced to 1. From cycle 5 onward, `p_o` equals P with bit 2 (interrupt disable) set.
- R5: Cycle 5 reads address 0xFF00 + T and cycle 6 reads address 0xFF00 + T + 1, both modulo 2^16. The byte read in cycle 5 becomes the new PC low byte and the byte read in cycle 6 becomes the new PC high byte.
- R6: When `is_brk_i` is 1, T is 0xFE whatever `type_i` holds. Otherwise T is `type_i`.
- R7: Cycle 7 reads at the new PC. Afterwards `pc_o` equals the new PC + 1.
- R8: `done_o` is high for exactly one cycle, the cycle right after cycle 7, and the block is then idle.
- R9: At most one of `rd_o` and `we_o` is high in any cycle. `we_o` is high only in cycles 2 to 4.
- R10: A start strobe that arrives while a sequence is running is ignored. The running sequence's addresses, data and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| is_brk_i | input | 1 | 1: software break, 0: hardware interrupt |
| type_i | input | 8 | Vector type byte for hardware interrupts |
| pc_i | input | 16 | PC at start |
| p_i | input | 8 | Status byte at start |
| s_i | input | 8 | Stack pointer at start |
| rdata_i | input | 8 | Read data, valid in the same cycle as the address |
| addr_o | output | 16 | Memory address |
| wdata_o | output | 8 | Write data |
| we_o | output | 1 | Write enable |
| rd_o | output | 1 | Read enable |
| pc_o | output | 16 | Updated PC |
| s_o | output | 8 | Updated stack pointer |
| p_o | output | 8 | Updated status byte |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The start strobe is taken on clock edge E0, and cycle k of the sequence lies between edge E(k−1) and edge Ek. The bench therefore checks the bus values of cycle k at the falling edge after E(k−1). It checks `p_o` and `s_o` from cycle 5 onward, because by then the pushes have been registered. It checks `done_o` and the final PC at the falling edge after E7, and checks that `done_o` has dropped one cycle after that. The expected values are rebuilt for each sequence from the start inputs and from a bench memory function, and are compared on every one of those cycles.

// File: rtl/brk_seq_pkg.sv
package brk_seq_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPER, ST_PUSH_HI, ST_PUSH_LO,
    ST_PUSH_P, ST_VEC_LO, ST_VEC_HI, ST_FETCH
  } step_e;

  localparam logic [DW-1:0] P_IRQ_OFF = 8'h04;
  localparam logic [DW-1:0] P_FORCED  = 8'h30;
endpackage

// File: rtl/brk_seq_ctrl.sv
module brk_seq_ctrl
  import brk_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  output step_e step_o,
  output logic  take_o,
  output logic  done_o
);
  step_e step_q;

  assign take_o = start_i && (step_q == ST_IDLE);
  assign step_o = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      done_o <= 1'b0;
    end else begin
      done_o <= (step_q == ST_FETCH);
      unique case (step_q)
        ST_IDLE:  if (start_i) step_q <= ST_OPER;
        ST_FETCH: step_q <= ST_IDLE;
        default:  step_q <= step_e'(step_q + 3'd1);
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_PUSH_HI) |=> (step_q == ST_PUSH_LO));
endmodule

// File: rtl/brk_seq_bus.sv
module brk_seq_bus
  import brk_seq_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [DW-1:0] VEC_PAGE   = 8'hFF
) (
  input  step_e          step_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [DW-1:0]  s_i,
  input  logic [DW-1:0]  p_i,
  input  logic [DW-1:0]  type_i,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  wdata_o,
  output logic           we_o,
  output logic           rd_o
);
  logic [AW-1:0] vec_lo, vec_hi, stk;

  assign vec_lo = {VEC_PAGE, {DW{1'b0}}} + AW'(type_i);
  assign vec_hi = vec_lo + AW'(1);
  assign stk    = {STACK_PAGE, s_i};

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    we_o    = 1'b0;
    rd_o    = 1'b0;
    unique case (step_i)
      ST_OPER, ST_FETCH: begin addr_o = pc_i; rd_o = 1'b1; end
      ST_PUSH_HI: begin addr_o = stk; wdata_o = pc_i[AW-1:DW]; we_o = 1'b1; end
      ST_PUSH_LO: begin addr_o = stk; wdata_o = pc_i[DW-1:0];  we_o = 1'b1; end
      ST_PUSH_P:  begin addr_o = stk; wdata_o = p_i | P_FORCED; we_o = 1'b1; end
      ST_VEC_LO:  begin addr_o = vec_lo; rd_o = 1'b1; end
      ST_VEC_HI:  begin addr_o = vec_hi; rd_o = 1'b1; end
      default: ;
    endcase
  end

  // R9
  one_access_chk: assert final (!(we_o && rd_o));
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_seq_pkg::*;
#(
  parameter logic [DW-1:0] BRK_TYPE = 8'hFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          is_brk_i,
  input  logic [7:0]    type_i,
  input  logic [15:0]   pc_i,
  input  logic [7:0]    p_i,
  input  logic [7:0]    s_i,
  input  logic [7:0]    rdata_i,
  output logic [15:0]   addr_o,
  output logic [7:0]    wdata_o,
  output logic          we_o,
  output logic          rd_o,
  output logic [15:0]   pc_o,
  output logic [7:0]    s_o,
  output logic [7:0]    p_o,
  output logic          done_o
);
  step_e         step;
  logic          take;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] s_q, p_q, type_q, vlo_q;
  logic          brk_q;

  brk_seq_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .step_o(step), .take_o(take), .done_o
  );

  brk_seq_bus u_bus (
    .step_i(step), .pc_i(pc_q), .s_i(s_q), .p_i(p_q), .type_i(type_q),
    .addr_o, .wdata_o, .we_o, .rd_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      s_q    <= '0;
      p_q    <= '0;
      type_q <= '0;
      vlo_q  <= '0;
      brk_q  <= 1'b0;
    end else if (take) begin
      pc_q   <= pc_i;
      s_q    <= s_i;
      p_q    <= p_i;
      brk_q  <= is_brk_i;
      type_q <= is_brk_i ? BRK_TYPE : type_i;
    end else begin
      unique case (step)
        ST_OPER:    if (brk_q) pc_q <= pc_q + AW'(1);
        ST_PUSH_HI,
        ST_PUSH_LO: s_q <= s_q - DW'(1);
        ST_PUSH_P: begin
          s_q <= s_q - DW'(1);
          p_q <= p_q | P_IRQ_OFF;
        end
        ST_VEC_LO:  vlo_q <= rdata_i;
        ST_VEC_HI:  pc_q  <= {rdata_i, vlo_q};
        ST_FETCH:   pc_q  <= pc_q + AW'(1);
        default: ;
      endcase
    end
  end

  assign pc_o = pc_q;
  assign s_o  = s_q;
  assign p_o  = p_q;

  // R3
  s_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (s_o == $past(s_o) - 8'd1));
  // R4
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_o) |-> p_o[2]);
  // R9
  we_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !$past(we_o)) |-> (done_o == 1'b0) ##1 we_o ##1 we_o ##1 !we_o);
endmodule

// File: tb/tb_brk_seq.sv
module tb_brk_seq;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0, rst_n = 0, start = 0, is_brk = 0;
  logic [7:0]  typ = 0, p = 0, s = 0, rdata;
  logic [15:0] pc = 0, addr, pc_o;
  logic [7:0]  wdata, s_o, p_o;
  logic        we, rd, done;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign rdata = mem_f(addr);

  brk_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .is_brk_i(is_brk),
    .type_i(typ), .pc_i(pc), .p_i(p), .s_i(s), .rdata_i(rdata),
    .addr_o(addr), .wdata_o(wdata), .we_o(we), .rd_o(rd),
    .pc_o(pc_o), .s_o(s_o), .p_o(p_o), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bus tuple {rd,we,addr,wdata}
  task automatic bus(input string tag, input logic r, input logic w,
                     input logic [15:0] a, input logic [7:0] d);
    chk(tag, {rd, we, addr, (w ? wdata : 8'h00)}, {r, w, a, d});
  endtask

  task automatic run_seq(input logic b, input logic [7:0] t, input logic [15:0] pc0,
                         input logic [7:0] p0, input logic [7:0] s0, input bit poke);
    logic [7:0]  te, ph;
    logic [15:0] pa, va, vb, np;
    te = b ? 8'hFE : t;
    pa = pc0 + 16'(b);
    va = 16'hFF00 + 16'(te);
    vb = va + 16'd1;
    np = {mem_f(vb), mem_f(va)};
    ph = p0 | 8'h30;
    @(negedge clk);
    start = 1; is_brk = b; typ = t; pc = pc0; p = p0; s = s0;
    @(negedge clk); start = 0;
    bus("R2 operand read", 1, 0, pc0, 0);
    @(negedge clk);
    chk("R2 pc advance", pc_o, pa);
    bus("R3 push pc hi", 0, 1, {8'h01, s0}, pa[15:8]);
    if (poke) begin start = 1; is_brk = 0; typ = 8'h10; pc = 16'h1111; s = 8'h22; p = 8'h00; end
    @(negedge clk); start = 0;
    bus("R3 push pc lo", 0, 1, {8'h01, 8'(s0 - 8'd1)}, pa[7:0]);
    @(negedge clk);
    bus("R4 push status", 0, 1, {8'h01, 8'(s0 - 8'd2)}, ph);
    @(negedge clk);
    bus("R5 vector lo", 1, 0, va, 0);
    chk("R4 irq disable", p_o, p0 | 8'h04);
    chk("R3 s wrap", s_o, 8'(s0 - 8'd3));
    @(negedge clk);
    bus("R5 vector hi", 1, 0, vb, 0);
    @(negedge clk);
    bus("R7 fetch new pc", 1, 0, np, 0);
    chk("R8 done early", done, 0);
    @(negedge clk);
    chk("R8 done pulse", {done, rd, we}, 3'b100);
    chk("R7 pc after", pc_o, np + 16'd1);
    if (poke) chk("R10 busy start ignored", {s_o, p_o}, {8'(s0 - 8'd3), p0 | 8'h04});
    @(negedge clk);
    chk("R8 done single", {done, rd, we}, 3'b000);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset bus", {rd, we, done}, 3'b000);
    chk("R1 reset regs", {pc_o, s_o, p_o}, 32'h0);
    rst_n = 1;
    run_seq(1, 8'h00, 16'h1234, 8'h81, 8'hFD, 0);   // R6 brk ignores type_i
    run_seq(0, 8'hFA, 16'hC000, 8'h00, 8'h40, 0);   // irq type
    run_seq(0, 8'hFF, 16'h0FFF, 8'h4B, 8'h01, 0);   // R5 vector wrap, R3 s wrap
    run_seq(1, 8'h33, 16'hFFFF, 8'hFF, 8'h00, 1);   // R2 pc wrap, R10
    run_seq(0, 8'hFE, 16'h8000, 8'h04, 8'h80, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule